// File: doc/BRIEF.md
# Ready-Valid Queue with Single-Cycle Flush

This block is a parameterised first-in first-out queue. Data enters through a ready/valid enqueue port and leaves through a ready/valid dequeue port. An occupancy count is always visible. A synchronous flush input empties the whole queue in one clock edge. Flush is meant for pipelines that must drop speculative or stale work. A typical case is a redirect, after which everything queued is invalid but the producer and consumer keep running.

The rules for a flush that meets a handshake in the same cycle are fixed:
- A dequeue in the flush cycle still completes, and the consumer receives the head entry.
- An element accepted in the flush cycle is dropped together with the rest.

Storage is picked by a parameter. It is either a read that is combinational from the slot array, or a head register that is loaded ahead of time. In both cases the output word is the true head whenever dequeue valid is high.

Top module: `rvf_queue`

## Requirements
- R1: With flush low, the dequeue port delivers accepted elements in acceptance order, each exactly once.
- R2: In the cycle after flush_i is high, count_o is 0, deq_valid_o is 0 and enq_ready_o is 1.
- R3: An element accepted by an enqueue handshake in a cycle where flush_i is high never appears at the dequeue port.
- R4: A dequeue handshake in a cycle where flush_i is high completes normally, and deq_data_o in that cycle is the oldest stored element.
- R5: Asserting flush_i on an empty queue leaves it empty, and later enqueues are accepted and delivered normally.
- R6: count_o reaches DEPTH when the queue is full, never exceeds DEPTH, and a flush of a full queue empties it. DEPTH may be any integer of at least 1.
- R7: enq_ready_o is 1 exactly when count_o < DEPTH, and deq_valid_o is 1 exactly when count_o != 0. Neither depends on the opposite port's inputs.
- R8: Without flush, count_o rises by one after an enqueue-only cycle, falls by one after a dequeue-only cycle, and is unchanged when both or neither fire.
- R9: With registered-read storage (RD_MODE = RD_REG), deq_data_o equals the head element whenever deq_valid_o is 1. This includes a write into an empty queue and the first write after a flush.
- R10: While deq_valid_o is 1 and deq_ready_i is 0 with flush low, deq_valid_o stays 1 and deq_data_o stays unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Synchronous discard of all stored elements |
| enq_valid_i | input | 1 | Producer offers an element |
| enq_ready_o | output | 1 | Queue can accept an element |
| enq_data_i | input | DATA_W | Offered element |
| deq_valid_o | output | 1 | Head element is available |
| deq_ready_i | input | 1 | Consumer takes the head element |
| deq_data_o | output | DATA_W | Head element |
| count_o | output | $clog2(DEPTH+1) | Number of stored elements |

## Verification
The bench builds three copies of the queue and drives them side by side:
- DEPTH 5 with combinational read. A depth that is not a power of two exercises the pointer wrap and the count arithmetic across the wrap.
- DEPTH 4 with registered read. This covers the head-register bypass when a write lands in the slot that is about to become the head, including right after a flush.
- DEPTH 1 with registered read. Full and empty are then separated by the maybe-full state alone, so every enqueue and every flush hits a boundary.

Directed phases cover flush on empty, flush on full, enqueue during flush and dequeue during flush. A long random phase then mixes all of them.

// File: rtl/rvf_pkg.sv
package rvf_pkg;
  // storage read style
  typedef enum logic {
    RD_COMB = 1'b0,
    RD_REG  = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/rvf_ptr.sv
module rvf_ptr #(
  parameter int DEPTH = 4,
  parameter int AW    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [AW-1:0] ptr_o,
  output logic [AW-1:0] nxt_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_q;

  always_comb begin
    if (clr_i)      nxt_o = '0;
    else if (adv_i) nxt_o = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    else            nxt_o = ptr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= nxt_o;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/rvf_ctrl.sv
module rvf_ctrl #(
  parameter int DEPTH = 4,
  parameter int AW    = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             enq_valid_i,
  input  logic             deq_ready_i,
  output logic             enq_ready_o,
  output logic             deq_valid_o,
  output logic             wr_en_o,
  output logic [AW-1:0]    waddr_o,
  output logic [AW-1:0]    raddr_o,
  output logic [AW-1:0]    raddr_nxt_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic          enq_fire, deq_fire;
  logic          maybe_full_q;
  logic          ptr_eq;
  logic [AW-1:0] wptr, rptr, wptr_nxt;
  logic [CNT_W-1:0] w_ext, r_ext;

  assign ptr_eq      = (wptr == rptr);
  assign enq_ready_o = !(ptr_eq && maybe_full_q);
  assign deq_valid_o = !(ptr_eq && !maybe_full_q);
  assign enq_fire    = enq_valid_i && enq_ready_o;
  assign deq_fire    = deq_ready_i && deq_valid_o;

  rvf_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (flush_i),
    .adv_i (enq_fire),
    .ptr_o (wptr),
    .nxt_o (wptr_nxt)
  );

  rvf_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (flush_i),
    .adv_i (deq_fire),
    .ptr_o (rptr),
    .nxt_o (raddr_nxt_o)
  );

  // wptr == rptr is ambiguous; this bit separates full from empty
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   maybe_full_q <= 1'b0;
    else if (flush_i)              maybe_full_q <= 1'b0;
    else if (enq_fire != deq_fire) maybe_full_q <= enq_fire;
  end

  assign w_ext = CNT_W'(wptr);
  assign r_ext = CNT_W'(rptr);

  always_comb begin
    if (ptr_eq)              count_o = maybe_full_q ? DEPTH_C : '0;
    else if (w_ext > r_ext)  count_o = w_ext - r_ext;
    else                     count_o = DEPTH_C - r_ext + w_ext;
  end

  assign wr_en_o = enq_fire;
  assign waddr_o = wptr;
  assign raddr_o = rptr;

  logic unused_nxt;
  assign unused_nxt = ^wptr_nxt;
endmodule

// File: rtl/rvf_store.sv
module rvf_store #(
  parameter int               DATA_W  = 8,
  parameter int               DEPTH   = 4,
  parameter int               AW      = 2,
  parameter rvf_pkg::rd_mode_e RD_MODE = rvf_pkg::RD_COMB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  input  logic [AW-1:0]     raddr_nxt_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[waddr_i] <= wdata_i;
  end

  generate
    if (RD_MODE == rvf_pkg::RD_REG) begin : g_reg_rd
      logic [DATA_W-1:0] head_q;
      // prefetch next head; forward a write landing in that slot
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                             head_q <= '0;
        else if (wr_en_i && waddr_i == raddr_nxt_i) head_q <= wdata_i;
        else                                     head_q <= mem_q[raddr_nxt_i];
      end
      assign rdata_o = head_q;
      logic unused_raddr;
      assign unused_raddr = ^raddr_i;
    end else begin : g_comb_rd
      assign rdata_o = mem_q[raddr_i];
      logic unused_nxt;
      assign unused_nxt = ^raddr_nxt_i;
    end
  endgenerate
endmodule

// File: rtl/rvf_queue.sv
module rvf_queue #(
  parameter int                DATA_W  = 8,
  parameter int                DEPTH   = 4,
  parameter rvf_pkg::rd_mode_e RD_MODE = rvf_pkg::RD_COMB,
  localparam int               AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int               CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              enq_valid_i,
  output logic              enq_ready_o,
  input  logic [DATA_W-1:0] enq_data_i,
  output logic              deq_valid_o,
  input  logic              deq_ready_i,
  output logic [DATA_W-1:0] deq_data_o,
  output logic [CNT_W-1:0]  count_o
);
  logic          wr_en;
  logic [AW-1:0] waddr, raddr, raddr_nxt;

  rvf_ctrl #(.DEPTH(DEPTH), .AW(AW), .CNT_W(CNT_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .enq_valid_i(enq_valid_i),
    .deq_ready_i(deq_ready_i),
    .enq_ready_o(enq_ready_o),
    .deq_valid_o(deq_valid_o),
    .wr_en_o    (wr_en),
    .waddr_o    (waddr),
    .raddr_o    (raddr),
    .raddr_nxt_o(raddr_nxt),
    .count_o    (count_o)
  );

  rvf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW), .RD_MODE(RD_MODE)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .waddr_i    (waddr),
    .wdata_i    (enq_data_i),
    .raddr_i    (raddr),
    .raddr_nxt_i(raddr_nxt),
    .rdata_o    (deq_data_o)
  );
endmodule

// File: rtl/rvf_queue_chk.sv
module rvf_queue_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              flush_i,
  input logic              enq_valid_i,
  input logic              enq_ready_o,
  input logic              deq_valid_o,
  input logic              deq_ready_i,
  input logic [DATA_W-1:0] deq_data_o,
  input logic [CNT_W-1:0]  count_o
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

  logic enq_fire, deq_fire;
  assign enq_fire = enq_valid_i && enq_ready_o;
  assign deq_fire = deq_valid_o && deq_ready_i;

  AST_FLUSH_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> count_o == '0); // R2
  AST_FLUSH_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !deq_valid_o); // R2
  AST_FLUSH_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> enq_ready_o); // R2
  AST_COUNT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= DEPTH_C); // R6
  AST_READY_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enq_ready_o == (count_o < DEPTH_C)); // R7
  AST_VALID_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deq_valid_o == (count_o != '0)); // R7
  AST_COUNT_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && enq_fire && !deq_fire) |=> count_o == CNT_W'($past(count_o) + ONE_C)); // R8
  AST_COUNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && !enq_fire && deq_fire) |=> count_o == CNT_W'($past(count_o) - ONE_C)); // R8
  AST_COUNT_SAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && enq_fire == deq_fire) |=> $stable(count_o)); // R8
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deq_valid_o && !deq_ready_i && !flush_i) |=> deq_valid_o && $stable(deq_data_o)); // R10
endmodule

bind rvf_queue rvf_queue_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .flush_i    (flush_i),
  .enq_valid_i(enq_valid_i),
  .enq_ready_o(enq_ready_o),
  .deq_valid_o(deq_valid_o),
  .deq_ready_i(deq_ready_i),
  .deq_data_o (deq_data_o),
  .count_o    (count_o)
);

// File: tb/rvf_queue_bench.sv
module rvf_lane #(
  parameter int                DEPTH   = 4,
  parameter rvf_pkg::rd_mode_e RD_MODE = rvf_pkg::RD_COMB
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       flush_i,
  input  logic       enq_valid_i,
  input  logic [7:0] enq_data_i,
  input  logic       deq_ready_i,
  output int         checks_o,
  output int         fails_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             enq_ready, deq_valid;
  logic [7:0]       deq_data;
  logic [CNT_W-1:0] count;

  rvf_queue #(.DATA_W(8), .DEPTH(DEPTH), .RD_MODE(RD_MODE)) u_rvf_queue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .enq_valid_i(enq_valid_i),
    .enq_ready_o(enq_ready),
    .enq_data_i (enq_data_i),
    .deq_valid_o(deq_valid),
    .deq_ready_i(deq_ready_i),
    .deq_data_o (deq_data),
    .count_o    (count)
  );

  int q[$];
  int checks = 0;
  int fails  = 0;
  bit flush_prev = 0, flush_prev_empty = 0, disc_pending = 0, stall_prev = 0;

  assign checks_o = checks;
  assign fails_o  = fails;

  task automatic chk(input int req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL R%0d depth=%0d %s act=%0d exp=%0d t=%0t", req, DEPTH, what, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      q.delete();
      flush_prev = 0; flush_prev_empty = 0; disc_pending = 0; stall_prev = 0;
      // reset state, R7
      chk(7, "reset count", int'(count), 0);
      chk(7, "reset valid", int'(deq_valid), 0);
    end else begin
      int  sz;
      bit  ev, er, ef, df;
      sz = q.size();
      ev = (sz > 0);
      er = (sz < DEPTH);
      // count: R5 after empty flush, R2 after flush, R3 after discarded enqueue, R6 full, else R8
      chk(flush_prev_empty ? 5 : flush_prev ? 2 : disc_pending ? 3 : (sz == DEPTH) ? 6 : 8,
          "count", int'(count), sz);
      chk(flush_prev ? 2 : (sz == DEPTH) ? 6 : 7, "enq_ready", int'(enq_ready), int'(er));
      chk(flush_prev ? 2 : 7, "deq_valid", int'(deq_valid), int'(ev));
      if (ev && deq_valid) begin
        // R4 head in flush cycle, R3 no discarded element, R10 stall hold, R9 reg read, R1 order
        chk((flush_i && deq_ready_i) ? 4 : disc_pending ? 3 : stall_prev ? 10 :
            (RD_MODE == rvf_pkg::RD_REG) ? 9 : 1, "deq_data", int'(deq_data), q[0]);
        disc_pending = 0;
      end
      ef = enq_valid_i && er;
      df = deq_ready_i && ev;
      stall_prev       = ev && !deq_ready_i && !flush_i;
      flush_prev       = flush_i;
      flush_prev_empty = flush_i && (sz == 0) && !ef;
      if (df) void'(q.pop_front());
      if (flush_i) begin
        if (ef) disc_pending = 1;
        q.delete();
      end else if (ef) begin
        q.push_back(int'(enq_data_i));
      end
    end
  end
endmodule

module rvf_queue_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       flush = 0, ev = 0, dr = 0;
  logic [7:0] ed = '0;
  int c0, f0, c1, f1, c2, f2;
  int wd_fail = 0;
  bit done = 0;

  always #4ns clk = ~clk;

  rvf_lane #(.DEPTH(5), .RD_MODE(rvf_pkg::RD_COMB)) u_lane5 (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .enq_valid_i(ev),
    .enq_data_i(ed), .deq_ready_i(dr), .checks_o(c0), .fails_o(f0));
  rvf_lane #(.DEPTH(4), .RD_MODE(rvf_pkg::RD_REG)) u_lane4 (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .enq_valid_i(ev),
    .enq_data_i(ed), .deq_ready_i(dr), .checks_o(c1), .fails_o(f1));
  rvf_lane #(.DEPTH(1), .RD_MODE(rvf_pkg::RD_REG)) u_lane1 (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .enq_valid_i(ev),
    .enq_data_i(ed), .deq_ready_i(dr), .checks_o(c1_dummy_c), .fails_o(c1_dummy_f));

  int c1_dummy_c, c1_dummy_f;
  assign c2 = c1_dummy_c;
  assign f2 = c1_dummy_f;

  logic [7:0] seq = 8'h10;

  task automatic drive(input bit f, input bit v, input bit r, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2ns;
      flush = f; ev = v; dr = r;
      seq = seq + 8'd1; ed = seq;
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", c0 + c1 + c2 + 1, f0 + f1 + f2 + wd_fail);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2ns rst_n = 1;
    drive(1, 0, 0, 1);            // R5 flush on empty
    drive(0, 1, 0, 3);            // enqueue after empty flush
    drive(0, 0, 1, 4);            // R1 drain in order
    drive(0, 1, 0, 7);            // R6 fill to full
    drive(0, 0, 0, 3);            // R10 stall while full
    drive(1, 0, 0, 1);            // R6 flush full
    drive(1, 1, 0, 1);            // R3 enqueue during flush on empty
    drive(0, 0, 1, 2);
    drive(0, 1, 0, 2);
    drive(1, 1, 1, 1);            // R4 dequeue plus R3 enqueue in flush cycle
    drive(0, 1, 1, 6);            // R9 write to empty head slot after flush
    drive(0, 0, 1, 3);
    for (int k = 0; k < 2500; k++) begin
      drive(($urandom_range(0, 19) == 0), $urandom_range(0, 1) == 1,
            $urandom_range(0, 2) != 0, 1);
    end
    drive(0, 0, 0, 3);
    done = 1;
    // final self-consistency check counted as one: watchdog did not fire
    if (wd_fail != 0) $display("FAIL R1 watchdog act=1 exp=0");
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      wd_fail = 1;
      $display("FAIL R1 watchdog expired act=1 exp=0");
      report();
      $finish;
    end
  end
endmodule